// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block models a single-port synchronous static RAM for a pipelined host. Address, bank select, byte-lane enables and the command are registered on the rising clock edge. A read returns its word one full cycle later, through a registered output. A write takes its data on the edge after the command. That data waits in a one-entry write buffer and reaches the array on the following edge. A read that targets the word held in the buffer gets the buffered lanes merged over the stored word, so no stale data is ever returned.

A strap input picks between two addressing schemes. In conventional mode the bank-select input is one more address bit, sampled with the rest of the address. In late-select mode the storage is two banks. A write still samples the bank select with its address. A read samples it one edge later, so the bank choice can arrive late. The output-drive enable and the sleep input act without waiting for a clock edge.

Top module: `lw_sram`

## Requirements
- R1: Synchronous active-high reset clears the read pipeline and the pending write, so the bus is not driven after reset. Stored words are not cleared.
- R2: A read registered on edge k places its word on `dq_out` at edge k+1, with `dq_oe` high when `out_en` is high. `dq_out` holds its value in every cycle without a read result.
- R3: For a write registered on edge k, the data is sampled from `dq_in` on edge k+1. The value on `dq_in` during the command cycle has no effect.
- R4: A read issued on the edge that captures a write's data returns that new data (full read/write coherency).
- R5: `lane_en[l]` enables writing bits [9l+8:9l]. Lanes that are not enabled keep their old contents. Back-to-back writes to one word each apply their own lanes.
- R6: When a read hits a partially written buffer entry, the enabled buffered lanes are merged over the stored lanes.
- R7: With `conv_mode`=1, `bsel` is an address bit sampled with the address for both reads and writes. Words differing only in `bsel` are distinct.
- R8: With `conv_mode`=0, a write's bank is `bsel` at its command edge. A read's bank is `bsel` at the edge after its command edge (0 = bank 0, 1 = bank 1).
- R9: Drive for a read result lasts one cycle. After a deselect registered on edge d (following a read on d-1), `dq_oe` is high until edge d+1 and low after it.
- R10: `out_en` gates `dq_oe` immediately, with no clock edge needed.
- R11: While `sleep` is high, commands are ignored, stored contents are kept and `dq_oe` is low immediately.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sleep | input | 1 | Power-down: blocks commands and bus drive |
| conv_mode | input | 1 | 1 = conventional addressing, 0 = late bank select |
| cmd_sel | input | 1 | Command valid (chip selected) |
| cmd_wr | input | 1 | 1 = write, 0 = read, when selected |
| row | input | ROW_W | Word address within a bank |
| bsel | input | 1 | Bank select / extra address bit |
| lane_en | input | LANES | Per-lane write enables |
| dq_in | input | LANES*LANE_W | Write data, sampled one cycle after the command |
| out_en | input | 1 | Asynchronous output-drive enable |
| dq_out | output | LANES*LANE_W | Registered read data |
| dq_oe | output | 1 | Bus drive enable for `dq_out` |

## Verification
The bench aims at the cycle where a read overlaps a write still in the buffer. It does this once with all lanes and once with a partial write. A design without forwarding would return the previous word there, and a wrong merge would mix the lanes. It drives late-select reads whose command-cycle `bsel` differs from the next-cycle `bsel`. A design that sampled the bank too early would return the other bank's word. It also checks the following:
- Data presented during a write's command cycle must not be stored.
- The drive window must close on the second edge after a read.
- Commands issued under sleep must leave the stored data untouched, so a design that lets them through would show corrupted words or a spurious drive.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

  // Command held in the address stage after the capture edge.
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

endpackage

// File: rtl/lw_sram_bank.sv
// One bank of storage: asynchronous read, one write port with lane enables.
module lw_sram_bank #(
  parameter int ROW_W  = 5,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ROW_W
) (
  input  logic              clk,
  input  logic              wr,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [LANES-1:0]  wr_lanes,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_lanes[l]) mem[wr_row][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rd_data = mem[rd_row];

endmodule

// File: rtl/lw_sram_wbuf.sv
// One-entry late-write buffer plus the forwarding merge for reads.
module lw_sram_wbuf #(
  parameter int ROW_W  = 5,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [ROW_W-1:0]  cap_row,
  input  logic              cap_bank,
  input  logic [LANES-1:0]  cap_lanes,
  input  logic [DATA_W-1:0] cap_data,
  input  logic [ROW_W-1:0]  rd_row,
  input  logic              rd_bank,
  input  logic [DATA_W-1:0] arr_word,
  output logic [DATA_W-1:0] fwd_word,
  output logic              pend_vld,
  output logic [ROW_W-1:0]  pend_row,
  output logic              pend_bank,
  output logic [LANES-1:0]  pend_lanes,
  output logic [DATA_W-1:0] pend_data
);

  logic hit;

  always_ff @(posedge clk) begin
    if (rst) pend_vld <= 1'b0;
    else     pend_vld <= cap;
    if (cap) begin
      pend_row   <= cap_row;
      pend_bank  <= cap_bank;
      pend_lanes <= cap_lanes;
      pend_data  <= cap_data;
    end
  end

  assign hit = pend_vld && (pend_row == rd_row) && (pend_bank == rd_bank);

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign fwd_word[l*LANE_W +: LANE_W] = (hit && pend_lanes[l])
                                            ? pend_data[l*LANE_W +: LANE_W]
                                            : arr_word[l*LANE_W +: LANE_W];
    end
  endgenerate

endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int ROW_W  = 5,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic              conv_mode,
  input  logic              cmd_sel,
  input  logic              cmd_wr,
  input  logic [ROW_W-1:0]  row,
  input  logic              bsel,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DATA_W-1:0] dq_in,
  input  logic              out_en,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  op_e               op_q;
  logic [ROW_W-1:0]  row_q;
  logic              bank_q;
  logic [LANES-1:0]  lane_q;
  logic              rd_vld;
  logic              rd_bank;
  logic [DATA_W-1:0] bank_rd [2];
  logic [DATA_W-1:0] fwd_word;
  logic              pend_vld;
  logic [ROW_W-1:0]  pend_row;
  logic              pend_bank;
  logic [LANES-1:0]  pend_lanes;
  logic [DATA_W-1:0] pend_data;

  // Address stage: sleep turns any command into a no-op.
  always_ff @(posedge clk) begin
    if (rst) op_q <= OP_IDLE;
    else if (!sleep && cmd_sel) op_q <= cmd_wr ? OP_WRITE : OP_READ;
    else op_q <= OP_IDLE;
    row_q  <= row;
    bank_q <= bsel;
    lane_q <= lane_en;
  end

  // Writes always use the bank captured with the address; reads in
  // late-select mode take bsel at the output edge instead.
  assign rd_bank = conv_mode ? bank_q : bsel;

  lw_sram_wbuf #(.ROW_W(ROW_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
    .clk       (clk),
    .rst       (rst),
    .cap       (op_q == OP_WRITE),
    .cap_row   (row_q),
    .cap_bank  (bank_q),
    .cap_lanes (lane_q),
    .cap_data  (dq_in),
    .rd_row    (row_q),
    .rd_bank   (rd_bank),
    .arr_word  (bank_rd[rd_bank]),
    .fwd_word  (fwd_word),
    .pend_vld  (pend_vld),
    .pend_row  (pend_row),
    .pend_bank (pend_bank),
    .pend_lanes(pend_lanes),
    .pend_data (pend_data)
  );

  generate
    for (genvar b = 0; b < 2; b++) begin : g_bank
      lw_sram_bank #(.ROW_W(ROW_W), .LANES(LANES), .LANE_W(LANE_W)) u_bank (
        .clk     (clk),
        .wr      (pend_vld && (pend_bank == 1'(b))),
        .wr_row  (pend_row),
        .wr_lanes(pend_lanes),
        .wr_data (pend_data),
        .rd_row  (row_q),
        .rd_data (bank_rd[b])
      );
    end
  endgenerate

  // Output stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld <= 1'b0;
      dq_out <= '0;
    end else begin
      rd_vld <= (op_q == OP_READ);
      if (op_q == OP_READ) dq_out <= fwd_word;
    end
  end

  assign dq_oe = out_en && rd_vld && !sleep;

endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk
  import lw_sram_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              sleep,
  input logic              cmd_sel,
  input logic              cmd_wr,
  input logic              out_en,
  input logic              dq_oe,
  input logic [DATA_W-1:0] dq_out,
  input op_e               op_q,
  input logic              pend_vld
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!pend_vld && !dq_oe));

  p_read_drive_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_sel && !cmd_wr && !sleep) |=> ##1 ((out_en && !sleep) -> dq_oe));

  p_hold_out_r2: assert property (@(posedge clk) disable iff (rst)
    (op_q != OP_READ) |=> $stable(dq_out));

  p_wbuf_fill_r3: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_WRITE) |=> pend_vld);

  p_wbuf_drain_r3: assert property (@(posedge clk) disable iff (rst)
    (pend_vld && op_q != OP_WRITE) |=> !pend_vld);

  p_deselect_r9: assert property (@(posedge clk) disable iff (rst)
    !cmd_sel |=> ##1 !dq_oe);

  p_sleep_ignore_r11: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (op_q == OP_IDLE));

endmodule

bind lw_sram lw_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .sleep   (sleep),
  .cmd_sel (cmd_sel),
  .cmd_wr  (cmd_wr),
  .out_en  (out_en),
  .dq_oe   (dq_oe),
  .dq_out  (dq_out),
  .op_q    (op_q),
  .pend_vld(pend_vld)
);

// File: tb/lw_sram_test.sv
module lw_sram_test;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 5;
  localparam int LANES = 4;
  localparam int LANE_W = 9;
  localparam int DW = LANES * LANE_W;

  localparam logic [DW-1:0] Z  = '0;
  localparam logic [DW-1:0] D1 = {9'h101, 9'h102, 9'h103, 9'h104};
  localparam logic [DW-1:0] D2 = {9'h1F1, 9'h1F2, 9'h1F3, 9'h1F4};
  localparam logic [DW-1:0] D3 = {9'h033, 9'h034, 9'h035, 9'h036};
  localparam logic [DW-1:0] D4 = {9'h0A1, 9'h0A2, 9'h0A3, 9'h0A4};
  localparam logic [DW-1:0] D5 = {9'h150, 9'h151, 9'h152, 9'h153};
  // D2 lanes 0 and 2 merged over D1
  localparam logic [DW-1:0] M1 = {9'h101, 9'h1F2, 9'h103, 9'h1F4};

  typedef struct packed {
    logic            mode;
    logic            sel;
    logic            wr;
    logic [ROW_W-1:0] row;
    logic            b;
    logic [LANES-1:0] lanes;
    logic [DW-1:0]   din;
    logic            chk;
    logic [DW-1:0]   exp;
  } vec_t;

  localparam int NV = 24;
  // A read on row k is checked (chk) at row k+2, before that row is applied.
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 1'b1, 5'd3, 1'b0, 4'hF, Z,  1'b0, Z },  // 0 W r3
    '{1'b1, 1'b1, 1'b0, 5'd3, 1'b0, 4'h0, D1, 1'b0, Z },  // 1 R r3 during data (R4)
    '{1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 4'h0, Z,  1'b0, Z },  // 2
    '{1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 4'h0, Z,  1'b1, D1},  // 3 R4 forward
    '{1'b1, 1'b1, 1'b0, 5'd3, 1'b0, 4'h0, Z,  1'b0, Z },  // 4 R r3
    '{1'b1, 1'b1, 1'b1, 5'd3, 1'b0, 4'h5, Z,  1'b0, Z },  // 5 W r3 lanes 0,2
    '{1'b1, 1'b1, 1'b0, 5'd3, 1'b0, 4'h0, D2, 1'b1, D1},  // 6 R2 array read
    '{1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 4'h0, Z,  1'b0, Z },  // 7
    '{1'b1, 1'b1, 1'b0, 5'd3, 1'b0, 4'h0, Z,  1'b1, M1},  // 8 R6 merge
    '{1'b1, 1'b1, 1'b1, 5'd3, 1'b1, 4'hF, Z,  1'b0, Z },  // 9 W r3 addr bit 1
    '{1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 4'h0, D3, 1'b1, M1},  // 10 R5 committed lanes
    '{1'b1, 1'b1, 1'b0, 5'd3, 1'b1, 4'h0, Z,  1'b0, Z },  // 11
    '{1'b1, 1'b1, 1'b0, 5'd3, 1'b0, 4'h0, Z,  1'b0, Z },  // 12
    '{1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 4'h0, Z,  1'b1, D3},  // 13 R7
    '{1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 4'h0, Z,  1'b1, M1},  // 14 R7
    '{1'b1, 1'b1, 1'b1, 5'd6, 1'b0, 4'hF, Z,  1'b0, Z },  // 15 W r6 bank0
    '{1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 4'h0, D5, 1'b0, Z },  // 16
    '{1'b0, 1'b1, 1'b1, 5'd6, 1'b1, 4'hF, Z,  1'b0, Z },  // 17 late-select W bank1
    '{1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 4'h0, D4, 1'b0, Z },  // 18
    '{1'b0, 1'b1, 1'b0, 5'd6, 1'b0, 4'h0, Z,  1'b0, Z },  // 19 R, cmd bsel 0
    '{1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 4'h0, Z,  1'b0, Z },  // 20 late bsel 1
    '{1'b0, 1'b1, 1'b0, 5'd6, 1'b1, 4'h0, Z,  1'b1, D4},  // 21 R8, cmd bsel 1
    '{1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 4'h0, Z,  1'b0, Z },  // 22 late bsel 0
    '{1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 4'h0, Z,  1'b1, D5}   // 23 R8
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             sleep = 1'b0;
  logic             conv_mode = 1'b1;
  logic             cmd_sel = 1'b0;
  logic             cmd_wr = 1'b0;
  logic [ROW_W-1:0] row = '0;
  logic             bsel = 1'b0;
  logic [LANES-1:0] lane_en = '0;
  logic [DW-1:0]    dq_in = '0;
  logic             out_en = 1'b1;
  logic [DW-1:0]    dq_out;
  logic             dq_oe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  lw_sram #(.ROW_W(ROW_W), .LANES(LANES), .LANE_W(LANE_W)) uut (
    .clk(clk), .rst(rst), .sleep(sleep), .conv_mode(conv_mode),
    .cmd_sel(cmd_sel), .cmd_wr(cmd_wr), .row(row), .bsel(bsel),
    .lane_en(lane_en), .dq_in(dq_in), .out_en(out_en),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk_data(input string req, input logic [DW-1:0] exp);
    checks++;
    if (dq_out !== exp || dq_oe !== 1'b1) begin
      fails++;
      $display("FAIL %s: dq_out=%h oe=%b, expected %h oe=1", req, dq_out, dq_oe, exp);
    end
  endtask

  task automatic chk_oe(input string req, input logic exp);
    checks++;
    if (dq_oe !== exp) begin
      fails++;
      $display("FAIL %s: dq_oe=%b, expected %b", req, dq_oe, exp);
    end
  endtask

  // Called at a falling edge; applies inputs for one capture edge.
  task automatic step(input logic s, input logic w, input logic [ROW_W-1:0] r,
                      input logic b, input logic [LANES-1:0] l, input logic [DW-1:0] d);
    cmd_sel = s; cmd_wr = w; row = r; bsel = b; lane_en = l; dq_in = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk_oe("R1 reset", 1'b0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].chk) chk_data($sformatf("table row %0d", i), VECS[i].exp);
      conv_mode = VECS[i].mode;
      step(VECS[i].sel, VECS[i].wr, VECS[i].row, VECS[i].b, VECS[i].lanes, VECS[i].din);
    end
    conv_mode = 1'b1;

    // R3: data present in the command cycle is not the data written
    step(1, 1, 5'd10, 0, 4'hF, D5);
    step(0, 0, 5'd0, 0, 4'h0, D3);
    step(1, 0, 5'd10, 0, 4'h0, Z);
    step(0, 0, 5'd0, 0, 4'h0, Z);
    chk_data("R3 late data", D3);

    // R5: back-to-back writes, second touches lane 3 only
    step(1, 1, 5'd9, 0, 4'hF, Z);
    step(1, 1, 5'd9, 0, 4'h8, D1);
    step(0, 0, 5'd0, 0, 4'h0, D2);
    step(1, 0, 5'd9, 0, 4'h0, Z);
    step(0, 0, 5'd0, 0, 4'h0, Z);
    chk_data("R5 lane 3 only", {9'h1F1, 9'h102, 9'h103, 9'h104});

    // R9: drive window after a read followed by deselects
    step(1, 0, 5'd3, 0, 4'h0, Z);
    step(0, 0, 5'd0, 0, 4'h0, Z);
    chk_data("R9 drive held", M1);
    step(0, 0, 5'd0, 0, 4'h0, Z);
    chk_oe("R9 drive released", 1'b0);

    // R10: output enable acts without a clock
    step(1, 0, 5'd3, 0, 4'h0, Z);
    step(0, 0, 5'd0, 0, 4'h0, Z);
    out_en = 1'b0;
    #1;
    chk_oe("R10 oe low", 1'b0);
    out_en = 1'b1;
    #1;
    chk_oe("R10 oe high", 1'b1);

    // R11: sleep blocks drive, writes and reads
    sleep = 1'b1;
    #1;
    chk_oe("R11 drive off in sleep", 1'b0);
    step(1, 1, 5'd3, 0, 4'hF, Z);
    step(0, 0, 5'd0, 0, 4'h0, D4);
    step(1, 0, 5'd3, 0, 4'h0, Z);
    sleep = 1'b0;
    step(0, 0, 5'd0, 0, 4'h0, Z);
    chk_oe("R11 read in sleep ignored", 1'b0);
    step(1, 0, 5'd3, 0, 4'h0, Z);
    step(0, 0, 5'd0, 0, 4'h0, Z);
    chk_data("R11 contents kept", M1);

    finish_run();
  end

endmodule